// File: doc/BRIEF.md
# Processor Trap Entry Sequencer

This block decides how a small 32-bit soft processor enters a trap. Each cycle it looks at four request lines: hardware exception (an MMU fault is one kind), hardware break, software break and external interrupt. It also sees the current PC, the pending branch target, a delay-slot flag and the incoming machine status word. When it accepts a request, it raises `take_trap` for one cycle. On that same clock edge it commits the new PC, a link-register write, the updated status word, the syndrome word, the fault address and the branch-target capture.

The pipeline applies these results and flushes when `take_trap` is high. The block also tracks whether an MMU fault handler is running. A second MMU fault during that handler is reported on `recursive_fault` and no trap is entered.

Top module: `trap_entry_seq`

## Requirements
- R1: After reset, every output is zero, including `take_trap`, `link_we` and `recursive_fault`.
- R2: Vector addresses are fixed: interrupt goes to 0x10, hardware break to 0x18 and hardware exception to 0x20.
- R3: Link writes go with the trap kind. An exception writes PC+4 to register 17, an interrupt writes PC to register 14 and a hardware break writes PC to register 16. `link_we` pulses together with `take_trap`.
- R4: On every trap entry, status bit 13 (translation on) is copied into bit 14 and bit 11 (user mode) into bit 12. Bits 13 and 11 are then cleared, and all other status bits pass through from `status_in`.
- R5: An exception entry sets status bit 9 (exception in progress). A hardware or software break entry sets status bit 3 (break in progress).
- R6: On an exception entry, syndrome bit 12 equals `in_dslot`. When `in_dslot` is set, `branch_target` is captured into `btr_out`; otherwise `btr_out` holds its value.
- R7: The syndrome low five bits are set as follows:
  - For a non-MMU exception they are `exc_cause`.
  - For an MMU fault they are 17 for an instruction-side miss, 16 for a data-side miss, 19 for an instruction-side protection fault and 18 for a data-side protection fault.
  - Bit 10 is set only for a data-side store fault.
  - All other syndrome bits are zero.
- R8: An MMU fault entry latches `fault_vaddr` into `ear_out`. Other traps leave it unchanged.
- R9: Recursive MMU faults are flagged without entering a trap.
  - Taking an MMU fault marks the MMU handler as busy.
  - The busy mark clears on a cycle with no trap taken and status bit 9 of `status_in` low.
  - An MMU fault request while busy takes no trap and pulses `recursive_fault` for one cycle.
- R10: An interrupt is taken only when all of the following hold:
  - status bit 1 (interrupt enable) is set;
  - status bits 9 and 3 are clear;
  - `in_dslot` is low.
  Otherwise it is ignored.
- R11: With `EXC_EN` = 0, an exception request is ignored: no trap is taken and no output changes.
- R12: Simultaneous requests are served in this priority order: exception, hardware break, software break, interrupt. One trap is taken per pulse.
- R13: `take_trap` is a one-cycle pulse. All registered outputs hold their values whenever no trap is taken.
- R14: A software break jumps to `branch_target` and writes no link register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_exc | input | 1 | Hardware exception request |
| req_irq | input | 1 | External interrupt request |
| req_hwbrk | input | 1 | Hardware break request |
| req_swbrk | input | 1 | Software break request |
| exc_mmu | input | 1 | Exception is an MMU fault |
| mmu_ifetch | input | 1 | MMU fault on instruction side |
| mmu_prot | input | 1 | MMU fault is a protection violation (else a miss) |
| mmu_store | input | 1 | Faulting data access was a store |
| exc_cause | input | 5 | Cause code for non-MMU exceptions |
| fault_vaddr | input | XLEN | Faulting virtual address |
| cur_pc | input | XLEN | PC of the trapping instruction |
| branch_target | input | XLEN | Pending branch target |
| in_dslot | input | 1 | A delay slot is executing |
| status_in | input | XLEN | Current machine status word |
| take_trap | output | 1 | Trap accepted, outputs committed |
| new_pc | output | XLEN | Next fetch address |
| link_we | output | 1 | Link register write strobe |
| link_idx | output | 5 | Link register index |
| link_val | output | XLEN | Link value |
| status_out | output | XLEN | Updated status word |
| esr_out | output | XLEN | Exception syndrome |
| ear_out | output | XLEN | Fault address |
| btr_out | output | XLEN | Captured branch target |
| recursive_fault | output | 1 | Recursive MMU fault pulse |

## Verification
The assertions assume that the status word presented with a request is the one the pipeline really holds. They also assume `in_dslot` is low when a break is requested.

The stimulus follows this by changing inputs only between clock edges. It requests breaks only outside delay slots. Between MMU fault scenarios it inserts an idle cycle with status bit 9 low, so each scenario begins with the busy mark in a known state.

// File: rtl/trap_pkg.sv
package trap_pkg;
    typedef enum logic [2:0] {
        TK_NONE,
        TK_EXC,
        TK_HWBRK,
        TK_SWBRK,
        TK_IRQ
    } trap_kind_e;

    // status word bit positions; shadow bits sit one above their live bit
    localparam int ST_IE  = 1;
    localparam int ST_BIP = 3;
    localparam int ST_EIP = 9;
    localparam int ST_UM  = 11;
    localparam int ST_UMS = 12;
    localparam int ST_VM  = 13;
    localparam int ST_VMS = 14;

    // syndrome fields
    localparam int SY_STORE = 10;
    localparam int SY_DSLOT = 12;
    localparam logic [4:0] SY_IMISS = 5'd17;
    localparam logic [4:0] SY_DMISS = 5'd16;
    localparam logic [4:0] SY_IPROT = 5'd19;
    localparam logic [4:0] SY_DPROT = 5'd18;

    // link register indices
    localparam logic [4:0] LNK_EXC   = 5'd17;
    localparam logic [4:0] LNK_IRQ   = 5'd14;
    localparam logic [4:0] LNK_HWBRK = 5'd16;
endpackage

// File: rtl/trap_arb.sv
module trap_arb
    import trap_pkg::*;
#(
    parameter bit EXC_EN = 1'b1
) (
    input  logic       req_exc,
    input  logic       req_irq,
    input  logic       req_hwbrk,
    input  logic       req_swbrk,
    input  logic       exc_mmu,
    input  logic       mmu_busy,
    input  logic       irq_en,
    input  logic       exc_active,
    input  logic       brk_active,
    input  logic       in_dslot,
    output trap_kind_e kind,
    output logic       recursive
);
    logic exc_ok;
    logic irq_ok;

    generate
        if (EXC_EN) begin : g_exc
            assign exc_ok = req_exc;
        end else begin : g_noexc
            assign exc_ok = 1'b0;
        end
    endgenerate

    assign irq_ok    = req_irq & irq_en & ~exc_active & ~brk_active & ~in_dslot;
    assign recursive = exc_ok & exc_mmu & mmu_busy;

    always_comb begin
        if (recursive) begin
            kind = TK_NONE;
        end else if (exc_ok) begin
            kind = TK_EXC;
        end else if (req_hwbrk) begin
            kind = TK_HWBRK;
        end else if (req_swbrk) begin
            kind = TK_SWBRK;
        end else if (irq_ok) begin
            kind = TK_IRQ;
        end else begin
            kind = TK_NONE;
        end
    end
endmodule

// File: rtl/trap_syn.sv
module trap_syn
    import trap_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            exc_mmu,
    input  logic            mmu_ifetch,
    input  logic            mmu_prot,
    input  logic            mmu_store,
    input  logic [4:0]      exc_cause,
    input  logic            in_dslot,
    output logic [XLEN-1:0] syndrome
);
    logic [4:0] code;

    always_comb begin
        if (!exc_mmu) begin
            code = exc_cause;
        end else if (mmu_ifetch) begin
            code = mmu_prot ? SY_IPROT : SY_IMISS;
        end else begin
            code = mmu_prot ? SY_DPROT : SY_DMISS;
        end
        syndrome           = '0;
        syndrome[4:0]      = code;
        syndrome[SY_STORE] = exc_mmu & ~mmu_ifetch & mmu_store;
        syndrome[SY_DSLOT] = in_dslot;
    end
endmodule

// File: rtl/trap_msr.sv
module trap_msr
    import trap_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] status_in,
    input  trap_kind_e      kind,
    output logic [XLEN-1:0] status_new
);
    always_comb begin
        status_new         = status_in;
        status_new[ST_VMS] = status_in[ST_VM];
        status_new[ST_UMS] = status_in[ST_UM];
        status_new[ST_VM]  = 1'b0;
        status_new[ST_UM]  = 1'b0;
        if (kind == TK_EXC) begin
            status_new[ST_EIP] = 1'b1;
        end
        if (kind == TK_HWBRK || kind == TK_SWBRK) begin
            status_new[ST_BIP] = 1'b1;
        end
    end
endmodule

// File: rtl/trap_entry_seq.sv
module trap_entry_seq
    import trap_pkg::*;
#(
    parameter int              XLEN    = 32,
    parameter bit              EXC_EN  = 1'b1,
    parameter logic [XLEN-1:0] VEC_IRQ = 32'h10,
    parameter logic [XLEN-1:0] VEC_BRK = 32'h18,
    parameter logic [XLEN-1:0] VEC_EXC = 32'h20
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_exc,
    input  logic            req_irq,
    input  logic            req_hwbrk,
    input  logic            req_swbrk,
    input  logic            exc_mmu,
    input  logic            mmu_ifetch,
    input  logic            mmu_prot,
    input  logic            mmu_store,
    input  logic [4:0]      exc_cause,
    input  logic [XLEN-1:0] fault_vaddr,
    input  logic [XLEN-1:0] cur_pc,
    input  logic [XLEN-1:0] branch_target,
    input  logic            in_dslot,
    input  logic [XLEN-1:0] status_in,
    output logic            take_trap,
    output logic [XLEN-1:0] new_pc,
    output logic            link_we,
    output logic [4:0]      link_idx,
    output logic [XLEN-1:0] link_val,
    output logic [XLEN-1:0] status_out,
    output logic [XLEN-1:0] esr_out,
    output logic [XLEN-1:0] ear_out,
    output logic [XLEN-1:0] btr_out,
    output logic            recursive_fault
);
    localparam logic [XLEN-1:0] PC_STEP = XLEN'(4);

    typedef struct packed {
        logic            take;
        logic [XLEN-1:0] pc;
        logic            lwe;
        logic [4:0]      lidx;
        logic [XLEN-1:0] lval;
        logic [XLEN-1:0] st;
        logic [XLEN-1:0] esr;
        logic [XLEN-1:0] ear;
        logic [XLEN-1:0] btr;
        logic            rec;
        logic            busy;
    } seq_state_t;

    seq_state_t      st_d, st_q;
    trap_kind_e      kind;
    logic            recursive;
    logic [XLEN-1:0] syndrome;
    logic [XLEN-1:0] status_new;

    trap_arb #(.EXC_EN(EXC_EN)) u_arb (
        .req_exc   (req_exc),
        .req_irq   (req_irq),
        .req_hwbrk (req_hwbrk),
        .req_swbrk (req_swbrk),
        .exc_mmu   (exc_mmu),
        .mmu_busy  (st_q.busy),
        .irq_en    (status_in[ST_IE]),
        .exc_active(status_in[ST_EIP]),
        .brk_active(status_in[ST_BIP]),
        .in_dslot  (in_dslot),
        .kind      (kind),
        .recursive (recursive)
    );

    trap_syn #(.XLEN(XLEN)) u_syn (
        .exc_mmu   (exc_mmu),
        .mmu_ifetch(mmu_ifetch),
        .mmu_prot  (mmu_prot),
        .mmu_store (mmu_store),
        .exc_cause (exc_cause),
        .in_dslot  (in_dslot),
        .syndrome  (syndrome)
    );

    trap_msr #(.XLEN(XLEN)) u_msr (
        .status_in (status_in),
        .kind      (kind),
        .status_new(status_new)
    );

    always_comb begin
        st_d      = st_q;
        st_d.take = 1'b0;
        st_d.lwe  = 1'b0;
        st_d.rec  = 1'b0;
        if (kind != TK_NONE) begin
            st_d.take = 1'b1;
            st_d.st   = status_new;
        end
        case (kind)
            TK_EXC: begin
                st_d.pc   = VEC_EXC;
                st_d.lwe  = 1'b1;
                st_d.lidx = LNK_EXC;
                st_d.lval = cur_pc + PC_STEP;
                st_d.esr  = syndrome;
                if (in_dslot) begin
                    st_d.btr = branch_target;
                end
                if (exc_mmu) begin
                    st_d.ear  = fault_vaddr;
                    st_d.busy = 1'b1;
                end
            end
            TK_HWBRK: begin
                st_d.pc   = VEC_BRK;
                st_d.lwe  = 1'b1;
                st_d.lidx = LNK_HWBRK;
                st_d.lval = cur_pc;
            end
            TK_SWBRK: begin
                st_d.pc = branch_target;
            end
            TK_IRQ: begin
                st_d.pc   = VEC_IRQ;
                st_d.lwe  = 1'b1;
                st_d.lidx = LNK_IRQ;
                st_d.lval = cur_pc;
            end
            default: begin
                st_d.rec  = recursive;
                st_d.busy = st_q.busy & status_in[ST_EIP];
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign take_trap       = st_q.take;
    assign new_pc          = st_q.pc;
    assign link_we         = st_q.lwe;
    assign link_idx        = st_q.lidx;
    assign link_val        = st_q.lval;
    assign status_out      = st_q.st;
    assign esr_out         = st_q.esr;
    assign ear_out         = st_q.ear;
    assign btr_out         = st_q.btr;
    assign recursive_fault = st_q.rec;
endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk
    import trap_pkg::*;
#(
    parameter int              XLEN    = 32,
    parameter bit              EXC_EN  = 1'b1,
    parameter logic [XLEN-1:0] VEC_BRK = 32'h18
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_exc,
    input logic            req_irq,
    input logic            req_hwbrk,
    input logic            req_swbrk,
    input logic [XLEN-1:0] status_in,
    input logic            take_trap,
    input logic [XLEN-1:0] new_pc,
    input logic            link_we,
    input logic [XLEN-1:0] status_out,
    input logic            recursive_fault
);
    assert_live_cleared_R4: assert property (@(posedge clk) disable iff (!rst_n)
        take_trap |-> (!status_out[ST_VM] && !status_out[ST_UM]));

    assert_shadow_saved_R4: assert property (@(posedge clk) disable iff (!rst_n)
        take_trap |-> (status_out[ST_VMS] == $past(status_in[ST_VM]) &&
                       status_out[ST_UMS] == $past(status_in[ST_UM])));

    assert_rec_no_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
        recursive_fault |-> !take_trap);

    assert_irq_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_irq && !req_exc && !req_hwbrk && !req_swbrk && !status_in[ST_IE])
        |=> !take_trap);

    assert_hwbrk_vector_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_hwbrk && !req_exc) |=> (take_trap && new_pc == VEC_BRK && status_out[ST_BIP]));

    assert_link_with_take_R3: assert property (@(posedge clk) disable iff (!rst_n)
        link_we |-> take_trap);

    assert_pc_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !take_trap |-> $stable(new_pc));

    assert_exc_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!EXC_EN && req_exc && !req_hwbrk && !req_swbrk && !req_irq) |=> !take_trap);
endmodule

bind trap_entry_seq trap_entry_chk #(
    .XLEN   (XLEN),
    .EXC_EN (EXC_EN),
    .VEC_BRK(VEC_BRK)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_exc        (req_exc),
    .req_irq        (req_irq),
    .req_hwbrk      (req_hwbrk),
    .req_swbrk      (req_swbrk),
    .status_in      (status_in),
    .take_trap      (take_trap),
    .new_pc         (new_pc),
    .link_we        (link_we),
    .status_out     (status_out),
    .recursive_fault(recursive_fault)
);

// File: tb/test_trap_entry_seq.sv
module test_trap_entry_seq;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_exc = 0, req_irq = 0, req_hwbrk = 0, req_swbrk = 0;
    logic        exc_mmu = 0, mmu_ifetch = 0, mmu_prot = 0, mmu_store = 0;
    logic [4:0]  exc_cause = '0;
    logic [31:0] fault_vaddr = '0, cur_pc = '0, branch_target = '0, status_in = '0;
    logic        in_dslot = 0;

    logic        take_trap, link_we, recursive_fault;
    logic [4:0]  link_idx;
    logic [31:0] new_pc, link_val, status_out, esr_out, ear_out, btr_out;

    logic        t2, lwe2, rec2;
    logic [4:0]  li2;
    logic [31:0] pc2, lv2, st2, esr2, ear2, btr2;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    bit checking = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    trap_entry_seq i_trap_entry_seq (
        .clk(clk), .rst_n(rst_n), .req_exc(req_exc), .req_irq(req_irq),
        .req_hwbrk(req_hwbrk), .req_swbrk(req_swbrk), .exc_mmu(exc_mmu),
        .mmu_ifetch(mmu_ifetch), .mmu_prot(mmu_prot), .mmu_store(mmu_store),
        .exc_cause(exc_cause), .fault_vaddr(fault_vaddr), .cur_pc(cur_pc),
        .branch_target(branch_target), .in_dslot(in_dslot), .status_in(status_in),
        .take_trap(take_trap), .new_pc(new_pc), .link_we(link_we), .link_idx(link_idx),
        .link_val(link_val), .status_out(status_out), .esr_out(esr_out),
        .ear_out(ear_out), .btr_out(btr_out), .recursive_fault(recursive_fault)
    );

    trap_entry_seq #(.EXC_EN(1'b0)) i_trap_entry_seq_noexc (
        .clk(clk), .rst_n(rst_n), .req_exc(req_exc), .req_irq(req_irq),
        .req_hwbrk(req_hwbrk), .req_swbrk(req_swbrk), .exc_mmu(exc_mmu),
        .mmu_ifetch(mmu_ifetch), .mmu_prot(mmu_prot), .mmu_store(mmu_store),
        .exc_cause(exc_cause), .fault_vaddr(fault_vaddr), .cur_pc(cur_pc),
        .branch_target(branch_target), .in_dslot(in_dslot), .status_in(status_in),
        .take_trap(t2), .new_pc(pc2), .link_we(lwe2), .link_idx(li2),
        .link_val(lv2), .status_out(st2), .esr_out(esr2),
        .ear_out(ear2), .btr_out(btr2), .recursive_fault(rec2)
    );

    // behavioural reference model
    logic        m_take = 0, m_lwe = 0, m_rec = 0, m_busy = 0;
    logic [4:0]  m_lidx = '0;
    logic [31:0] m_pc = '0, m_lval = '0, m_st = '0, m_esr = '0, m_ear = '0, m_btr = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_take = 0; m_lwe = 0; m_rec = 0; m_busy = 0; m_lidx = '0;
            m_pc = '0; m_lval = '0; m_st = '0; m_esr = '0; m_ear = '0; m_btr = '0;
        end else begin
            int which;
            int code;
            logic [31:0] s;
            m_take = 0; m_lwe = 0; m_rec = 0;
            which = 0;
            if (req_exc && exc_mmu && m_busy) m_rec = 1;
            else if (req_exc) which = 1;
            else if (req_hwbrk) which = 2;
            else if (req_swbrk) which = 3;
            else if (req_irq && status_in[1] && !status_in[9] && !status_in[3] && !in_dslot)
                which = 4;
            if (which == 0) begin
                if (!status_in[9]) m_busy = 0;
            end else begin
                m_take = 1;
                s = status_in & ~32'h0000_7800;
                s = s | ((status_in & 32'h0000_2800) << 1);
                if (which == 1) s[9] = 1;
                if (which == 2 || which == 3) s[3] = 1;
                m_st = s;
            end
            if (which == 1) begin
                m_pc = 32'h20; m_lwe = 1; m_lidx = 17; m_lval = cur_pc + 4;
                code = exc_mmu ? (16 + (mmu_ifetch ? 1 : 0) + (mmu_prot ? 2 : 0)) : int'(exc_cause);
                m_esr = 32'(code);
                if (exc_mmu && !mmu_ifetch && mmu_store) m_esr = m_esr | 32'h400;
                if (in_dslot) begin
                    m_esr = m_esr | 32'h1000;
                    m_btr = branch_target;
                end
                if (exc_mmu) begin
                    m_ear = fault_vaddr;
                    m_busy = 1;
                end
            end else if (which == 2) begin
                m_pc = 32'h18; m_lwe = 1; m_lidx = 16; m_lval = cur_pc;
            end else if (which == 3) begin
                m_pc = branch_target;
            end else if (which == 4) begin
                m_pc = 32'h10; m_lwe = 1; m_lidx = 14; m_lval = cur_pc;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // compare against the model every clock, away from the active edge
    always @(negedge clk) begin
        if (checking) begin
            chk("R13 take_trap", 32'(take_trap), 32'(m_take));
            chk("R2/R12/R14 new_pc", new_pc, m_pc);
            chk("R3 link_we", 32'(link_we), 32'(m_lwe));
            chk("R3 link_idx", 32'(link_idx), 32'(m_lidx));
            chk("R3 link_val", link_val, m_lval);
            chk("R4/R5 status_out", status_out, m_st);
            chk("R6/R7 esr_out", esr_out, m_esr);
            chk("R8 ear_out", ear_out, m_ear);
            chk("R6 btr_out", btr_out, m_btr);
            chk("R9 recursive_fault", 32'(recursive_fault), 32'(m_rec));
        end
    end

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        req_exc = 0; req_irq = 0; req_hwbrk = 0; req_swbrk = 0;
        exc_mmu = 0; mmu_ifetch = 0; mmu_prot = 0; mmu_store = 0;
        in_dslot = 0;
    endtask

    task automatic idle_clear();
        status_in = 32'h0;
        step();
    endtask

    task automatic mmu_fault(input logic ifl, input logic prot, input logic store,
                             input logic [31:0] va);
        req_exc = 1; exc_mmu = 1; mmu_ifetch = ifl; mmu_prot = prot; mmu_store = store;
        fault_vaddr = va; cur_pc = va ^ 32'h0F0F_0000;
        status_in = 32'h0000_2802;
        step();
    endtask

    initial begin
        logic [31:0] pc_before;
        @(negedge clk);
        // R1: reset values
        chk("R1 take_trap", 32'(take_trap), 0);
        chk("R1 new_pc", new_pc, 0);
        chk("R1 status_out", status_out, 0);
        chk("R1 esr_out", esr_out, 0);
        chk("R1 recursive_fault", 32'(recursive_fault), 0);
        checking = 1;
        step();
        rst_n = 1;
        step();

        // R10: interrupt accepted with enable set
        status_in = 32'h0000_2802; cur_pc = 32'h0000_1234; req_irq = 1;
        step();
        // R10: blocked by enable clear, exception active, break active, delay slot
        status_in = 32'h0000_2800; req_irq = 1; step();
        status_in = 32'h0000_0202; req_irq = 1; step();
        status_in = 32'h0000_000A; req_irq = 1; step();
        status_in = 32'h0000_0002; req_irq = 1; in_dslot = 1; step();
        idle_clear();

        // R2/R3/R5: hardware break
        status_in = 32'h0000_0800; cur_pc = 32'h0000_4000; req_hwbrk = 1; step();
        // R14: software break to branch target, no link
        status_in = 32'h0000_2000; branch_target = 32'h0000_8888; req_swbrk = 1; step();

        // R6/R7: non-MMU exception inside delay slot, then outside
        status_in = 32'h0000_2802; cur_pc = 32'h0000_0100; branch_target = 32'h0000_0200;
        exc_cause = 5'd5; req_exc = 1; in_dslot = 1; step();
        idle_clear();
        exc_cause = 5'd1; req_exc = 1; branch_target = 32'hDEAD_0000; step();
        idle_clear();

        // R7/R8: the four MMU fault kinds and store handling
        mmu_fault(1, 0, 0, 32'h1000_0010); idle_clear();
        mmu_fault(0, 0, 1, 32'h2000_0020); idle_clear();
        mmu_fault(1, 1, 1, 32'h3000_0030); idle_clear();
        mmu_fault(0, 1, 0, 32'h4000_0040); idle_clear();
        mmu_fault(0, 1, 1, 32'h5000_0050); idle_clear();

        // R9: recursive fault while the handler is active
        mmu_fault(0, 0, 0, 32'h6000_0060);
        status_in = 32'h0000_0200; step();
        mmu_fault(1, 0, 0, 32'h7000_0070);
        status_in = 32'h0000_0200; req_exc = 1; exc_cause = 5'd7; step();
        idle_clear();
        mmu_fault(1, 0, 0, 32'h7100_0070);
        idle_clear();

        // R12: priority among simultaneous requests
        status_in = 32'h0000_0002; cur_pc = 32'h0000_0500; branch_target = 32'h0000_0600;
        req_exc = 1; req_hwbrk = 1; req_swbrk = 1; req_irq = 1; exc_cause = 5'd2; step();
        idle_clear();
        status_in = 32'h0000_0002;
        req_hwbrk = 1; req_swbrk = 1; req_irq = 1; step();
        status_in = 32'h0000_0002;
        req_swbrk = 1; req_irq = 1; step();

        // R13: holding across idle cycles
        status_in = 32'h0000_0000; step(); step();

        // R11: exception request on a build without exception support
        pc_before = pc2;
        status_in = 32'h0000_2802; req_exc = 1; exc_cause = 5'd3; step();
        chk("R11 take_trap noexc", 32'(t2), 0);
        chk("R11 new_pc noexc", pc2, pc_before);
        chk("R11 recursive noexc", 32'(rec2), 0);
        idle_clear();

        checking = 0;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule